// File: doc/BRIEF.md
# Decode-Stage Branch Prediction Validator

This block sits in the decode stage and audits the guess the fetch-stage predictor made for every instruction in a decode group. Once decoding has revealed whether an instruction really is a control transfer, which kind it is, and where its relative target lies, the block compares those facts with the attached prediction. Direction of conditional branches and indirect targets are left for the execute stage. Every fault it can settle with static rules is fixed here, well before execution.

When a lane disagrees with its prediction, the block emits a one-cycle redirect to the correct next fetch address, a single update command for the fetch predictor, and a squash mask for the younger lanes of the group. It then holds fetch for a fixed number of cycles, during which decode input is treated as wrong-path traffic and ignored. A running count of decode-stage corrections is kept. A small return-address stack, fed by calls and drained by returns, supplies the expected target of return instructions.

All outputs are registered: a group presented before clock edge N produces its result in the cycle that follows edge N.

Top module: `bv_validator`

## Requirements
- R1: A valid lane of class 0 (not a branch) that carries a predictor hit is a mismatch: the redirect goes to pc+len, with update command 2 (remove) at that pc and zero target, always-taken and hint fields.
- R2: A valid lane of class 2 (relative jump) or class 3 (relative call) is a mismatch unless hit=1, taken=1 and the predicted target equals the computed target. The redirect goes to the computed target, with update command 1 (write), that target, always-taken=1 and hint=1.
- R3: A valid lane of class 1 (conditional) with a hit is a mismatch only when the predicted target differs from the computed one. The redirect goes to the target if the prediction said taken and to pc+len otherwise, with command 1, the computed target, always-taken=0 and hint equal to the predicted direction.
- R4: A valid conditional lane without a hit is always a mismatch and gets a new entry (command 1, always-taken=0) using a static rule. It is taken (hint=1, redirect to target) when the target is below the instruction address as an unsigned compare, and not taken (hint=0, redirect to pc+len) otherwise.
- R5: The computed target is pc + len + sign-extended displacement, modulo 2^ADDR_W.
- R6: Calls push pc+len on a RAS_DEPTH-entry return stack that drops its oldest entry when full. A valid lane of class 4 (return) with a non-empty stack pops it and is a mismatch unless hit=1, taken=1 and the predicted target equals the popped value. The fix is a redirect there with command 1, always-taken=1 and hint=1. A return on an empty stack is not checked.
- R7: Within a group, lane 0 being oldest, the oldest mismatching lane is reported. Every younger lane is flagged in squash_mask (bit j for lane j), and younger lanes neither push nor pop the return stack.
- R8: clear_count rises by exactly one with every redirect and holds otherwise.
- R9: After a redirect, fetch_hold is high for HOLD_CYC cycles starting with the redirect cycle. Decode groups presented while it is high are ignored, with no output and no stack change.
- R10: Class 5 (indirect) lanes, invalid lanes and correctly predicted lanes cause no redirect, no update and no squash.
- R11: After reset all outputs are zero and the return stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | LANES | Lane holds a decoded instruction |
| dec_class | input | 3*LANES | Instruction class per lane (0 other, 1 cond, 2 jump, 3 call, 4 return, 5 indirect) |
| dec_pc | input | ADDR_W*LANES | Instruction address per lane |
| dec_len | input | LEN_W*LANES | Instruction length in bytes per lane |
| dec_disp | input | DISP_W*LANES | Signed relative displacement per lane |
| pred_hit | input | LANES | Fetch predictor had an entry for the lane |
| pred_taken | input | LANES | Fetch predictor predicted taken |
| pred_target | input | ADDR_W*LANES | Target the fetch predictor supplied |
| redir_valid | output | 1 | Decode redirect pulse |
| redir_pc | output | ADDR_W | Corrected fetch address |
| upd_op | output | 2 | Predictor command: 0 none, 1 write, 2 remove |
| upd_pc | output | ADDR_W | Address of the entry to change |
| upd_target | output | ADDR_W | Target to store |
| upd_always | output | 1 | Entry must always predict taken |
| upd_hint | output | 1 | Initial direction for the entry |
| squash_mask | output | LANES | Younger lanes to discard |
| fetch_hold | output | 1 | Fetch is stalled |
| clear_count | output | CNT_W | Number of decode-stage corrections |

## Verification
Random groups of two lanes mix all six classes with predictions that are mostly right and sometimes corrupted in hit, direction or target. This separates the per-class rules from one another and covers ordering when both lanes disagree. Directed groups isolate cases random traffic seldom reaches: backward versus forward static direction, a target that wraps past the top of the address space, a return on an empty stack, stack overflow that drops the oldest return address, and a squashed call that must leave the stack untouched. A phantom presented during the hold window tells an ignored group apart from one that was acted on.

// File: rtl/bv_pkg.sv
// Shared encodings for the decode-stage branch validator.
// Assumes decode delivers the class codes below unchanged.
package bv_pkg;
    typedef enum logic [2:0] {
        CLS_OTHER = 3'd0,
        CLS_COND  = 3'd1,
        CLS_JUMP  = 3'd2,
        CLS_CALL  = 3'd3,
        CLS_RET   = 3'd4,
        CLS_IND   = 3'd5
    } bv_cls_e;

    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_WRITE  = 2'd1,
        UPD_REMOVE = 2'd2
    } bv_op_e;
endpackage

// File: rtl/bv_addr_calc.sv
// Per-lane address arithmetic: fall-through, relative target and whether
// that target lies below the instruction. Assumes ADDR_W > DISP_W.
module bv_addr_calc #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [LEN_W-1:0]  len,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] fall,
    output logic [ADDR_W-1:0] tgt,
    output logic              backward
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    // Widen the length and sign-extend the displacement, then add.
    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        fall     = pc + ADDR_W'(len);
        tgt      = fall + disp_ext;
        backward = (tgt < pc);
    end
endmodule

// File: rtl/bv_ras.sv
// Return-address stack with a per-lane view for a decode group.
// Lane i sees the stack after the pushes/pops of lanes 0..i-1; only the
// committed lanes change the stored state. Full stack drops its oldest entry.
module bv_ras #(
    parameter int LANES  = 2,
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        push,
    input  logic [LANES-1:0]        pop,
    input  logic [LANES-1:0]        commit,
    input  logic [LANES*ADDR_W-1:0] push_val,
    output logic [LANES*ADDR_W-1:0] view_top,
    output logic [LANES-1:0]        view_ok
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] stk [DEPTH];
    logic [PTR_W-1:0]  ptr;
    logic [CNT_W-1:0]  cnt;

    logic [ADDR_W-1:0] v_stk [DEPTH];
    logic [PTR_W-1:0]  v_ptr;
    logic [CNT_W-1:0]  v_cnt;

    logic [ADDR_W-1:0] n_stk [DEPTH];
    logic [PTR_W-1:0]  n_ptr;
    logic [CNT_W-1:0]  n_cnt;
    logic [ADDR_W-1:0] w_stk [DEPTH];
    logic [PTR_W-1:0]  w_ptr;
    logic [CNT_W-1:0]  w_cnt;

    // Walk the group in age order and expose the top seen by each lane.
    always_comb begin
        v_stk = stk;
        v_ptr = ptr;
        v_cnt = cnt;
        for (int i = 0; i < LANES; i++) begin
            view_ok[i] = (v_cnt != '0);
            view_top[i*ADDR_W +: ADDR_W] = v_stk[v_ptr];
            if (push[i]) begin
                v_ptr = (v_ptr == PTR_MAX) ? '0 : v_ptr + 1'b1;
                v_stk[v_ptr] = push_val[i*ADDR_W +: ADDR_W];
                v_cnt = (v_cnt == CNT_MAX) ? v_cnt : v_cnt + 1'b1;
            end else if (pop[i] && v_cnt != '0) begin
                v_ptr = (v_ptr == '0) ? PTR_MAX : v_ptr - 1'b1;
                v_cnt = v_cnt - 1'b1;
            end
        end
    end

    // Replay only the committed lanes to form the next stored state.
    always_comb begin
        w_stk = stk;
        w_ptr = ptr;
        w_cnt = cnt;
        n_stk = stk;
        n_ptr = ptr;
        n_cnt = cnt;
        for (int i = 0; i < LANES; i++) begin
            if (push[i]) begin
                w_ptr = (w_ptr == PTR_MAX) ? '0 : w_ptr + 1'b1;
                w_stk[w_ptr] = push_val[i*ADDR_W +: ADDR_W];
                w_cnt = (w_cnt == CNT_MAX) ? w_cnt : w_cnt + 1'b1;
            end else if (pop[i] && w_cnt != '0) begin
                w_ptr = (w_ptr == '0) ? PTR_MAX : w_ptr - 1'b1;
                w_cnt = w_cnt - 1'b1;
            end
            if (commit[i]) begin
                n_stk = w_stk;
                n_ptr = w_ptr;
                n_cnt = w_cnt;
            end
        end
    end

    // Register the stack; reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            cnt <= '0;
            for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
        end else begin
            ptr <= n_ptr;
            cnt <= n_cnt;
            stk <= n_stk;
        end
    end

    // R6: the occupancy never exceeds the stack depth.
    p_depth_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);

    // R6: a group with no pushes or pops leaves the occupancy alone.
    p_idle_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push == '0 && pop == '0) |=> $stable(cnt));
endmodule

// File: rtl/bv_rule.sv
// Static check of one lane: compares the fetch prediction with decoded
// facts and proposes the next fetch address and a predictor update.
// Assumes addresses and the return-stack view come from their own blocks.
module bv_rule
    import bv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              valid,
    input  logic [2:0]        cls,
    input  logic              hit,
    input  logic              taken,
    input  logic [ADDR_W-1:0] ptgt,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] fall,
    input  logic [ADDR_W-1:0] tgt,
    input  logic              backward,
    input  logic              ras_ok,
    input  logic [ADDR_W-1:0] ras_top,
    output logic              mis,
    output logic [ADDR_W-1:0] npc,
    output logic [1:0]        op,
    output logic [ADDR_W-1:0] upc,
    output logic [ADDR_W-1:0] utgt,
    output logic              always_tk,
    output logic              hint
);
    // Apply the per-class rule; only a valid lane may raise a mismatch.
    always_comb begin
        mis       = 1'b0;
        npc       = fall;
        op        = UPD_NONE;
        upc       = pc;
        utgt      = '0;
        always_tk = 1'b0;
        hint      = 1'b0;
        unique case (bv_cls_e'(cls))
            CLS_OTHER: begin
                mis = hit;
                op  = UPD_REMOVE;
            end
            CLS_COND: begin
                op   = UPD_WRITE;
                utgt = tgt;
                if (!hit) begin
                    mis  = 1'b1;
                    hint = backward;
                    npc  = backward ? tgt : fall;
                end else begin
                    mis  = (ptgt != tgt);
                    hint = taken;
                    npc  = taken ? tgt : fall;
                end
            end
            CLS_JUMP, CLS_CALL: begin
                mis       = !hit || !taken || (ptgt != tgt);
                npc       = tgt;
                op        = UPD_WRITE;
                utgt      = tgt;
                always_tk = 1'b1;
                hint      = 1'b1;
            end
            CLS_RET: begin
                mis       = ras_ok && (!hit || !taken || (ptgt != ras_top));
                npc       = ras_top;
                op        = UPD_WRITE;
                utgt      = ras_top;
                always_tk = 1'b1;
                hint      = 1'b1;
            end
            default: begin
                mis = 1'b0;
            end
        endcase
        if (!valid) mis = 1'b0;
    end
endmodule

// File: rtl/bv_validator.sv
// Decode-stage branch prediction validator (top). Checks each lane of a
// decode group, picks the oldest mismatch, and issues a registered redirect,
// predictor update and squash mask, then holds fetch for HOLD_CYC cycles.
// Assumes lane 0 is the oldest instruction of the group.
module bv_validator
    import bv_pkg::*;
#(
    parameter int LANES     = 2,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 4,
    parameter int DISP_W    = 16,
    parameter int RAS_DEPTH = 4,
    parameter int HOLD_CYC  = 8,
    parameter int CNT_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        dec_valid,
    input  logic [LANES*3-1:0]      dec_class,
    input  logic [LANES*ADDR_W-1:0] dec_pc,
    input  logic [LANES*LEN_W-1:0]  dec_len,
    input  logic [LANES*DISP_W-1:0] dec_disp,
    input  logic [LANES-1:0]        pred_hit,
    input  logic [LANES-1:0]        pred_taken,
    input  logic [LANES*ADDR_W-1:0] pred_target,
    output logic                    redir_valid,
    output logic [ADDR_W-1:0]       redir_pc,
    output logic [1:0]              upd_op,
    output logic [ADDR_W-1:0]       upd_pc,
    output logic [ADDR_W-1:0]       upd_target,
    output logic                    upd_always,
    output logic                    upd_hint,
    output logic [LANES-1:0]        squash_mask,
    output logic                    fetch_hold,
    output logic [CNT_W-1:0]        clear_count
);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYC);

    logic [LANES*ADDR_W-1:0] l_fall, l_tgt, l_npc, l_upc, l_utgt, r_top;
    logic [LANES-1:0]        l_back, l_mis, l_alw, l_hint, r_ok;
    logic [LANES*2-1:0]      l_op;
    logic [LANES-1:0]        r_push, r_pop, r_commit;

    logic [HOLD_W-1:0] hold_cnt;
    logic              accept;
    logic              found;
    logic [LANE_W-1:0] win;

    assign accept = (hold_cnt == '0);

    // One address calculator and one rule checker per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bv_addr_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DISP_W(DISP_W)) u_calc (
            .pc       (dec_pc[g*ADDR_W +: ADDR_W]),
            .len      (dec_len[g*LEN_W +: LEN_W]),
            .disp     (dec_disp[g*DISP_W +: DISP_W]),
            .fall     (l_fall[g*ADDR_W +: ADDR_W]),
            .tgt      (l_tgt[g*ADDR_W +: ADDR_W]),
            .backward (l_back[g])
        );

        bv_rule #(.ADDR_W(ADDR_W)) u_rule (
            .valid     (dec_valid[g]),
            .cls       (dec_class[g*3 +: 3]),
            .hit       (pred_hit[g]),
            .taken     (pred_taken[g]),
            .ptgt      (pred_target[g*ADDR_W +: ADDR_W]),
            .pc        (dec_pc[g*ADDR_W +: ADDR_W]),
            .fall      (l_fall[g*ADDR_W +: ADDR_W]),
            .tgt       (l_tgt[g*ADDR_W +: ADDR_W]),
            .backward  (l_back[g]),
            .ras_ok    (r_ok[g]),
            .ras_top   (r_top[g*ADDR_W +: ADDR_W]),
            .mis       (l_mis[g]),
            .npc       (l_npc[g*ADDR_W +: ADDR_W]),
            .op        (l_op[g*2 +: 2]),
            .upc       (l_upc[g*ADDR_W +: ADDR_W]),
            .utgt      (l_utgt[g*ADDR_W +: ADDR_W]),
            .always_tk (l_alw[g]),
            .hint      (l_hint[g])
        );

        assign r_push[g] = dec_valid[g] && (dec_class[g*3 +: 3] == CLS_CALL);
        assign r_pop[g]  = dec_valid[g] && (dec_class[g*3 +: 3] == CLS_RET);
    end

    // Priority pick: the lowest-numbered mismatching lane wins.
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (l_mis[i]) begin
                found = 1'b1;
                win   = LANE_W'(i);
            end
        end
    end

    // Lanes up to and including the winner update the return stack.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            r_commit[i] = accept && (!found || (LANE_W'(i) <= win));
        end
    end

    bv_ras #(.LANES(LANES), .ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (r_push & {LANES{accept}}),
        .pop      (r_pop & {LANES{accept}}),
        .commit   (r_commit),
        .push_val (l_fall),
        .view_top (r_top),
        .view_ok  (r_ok)
    );

    // Register the correction outputs, hold counter and event count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            upd_op      <= UPD_NONE;
            upd_pc      <= '0;
            upd_target  <= '0;
            upd_always  <= 1'b0;
            upd_hint    <= 1'b0;
            squash_mask <= '0;
            hold_cnt    <= '0;
            clear_count <= '0;
        end else begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            upd_op      <= UPD_NONE;
            upd_pc      <= '0;
            upd_target  <= '0;
            upd_always  <= 1'b0;
            upd_hint    <= 1'b0;
            squash_mask <= '0;
            hold_cnt    <= (hold_cnt != '0) ? hold_cnt - 1'b1 : '0;
            if (accept && found) begin
                redir_valid <= 1'b1;
                redir_pc    <= l_npc[win*ADDR_W +: ADDR_W];
                upd_op      <= l_op[win*2 +: 2];
                upd_pc      <= l_upc[win*ADDR_W +: ADDR_W];
                upd_target  <= l_utgt[win*ADDR_W +: ADDR_W];
                upd_always  <= l_alw[win];
                upd_hint    <= l_hint[win];
                for (int j = 0; j < LANES; j++) begin
                    squash_mask[j] <= (LANE_W'(j) > win);
                end
                hold_cnt    <= HOLD_LOAD;
                clear_count <= clear_count + 1'b1;
            end
        end
    end

    assign fetch_hold = (hold_cnt != '0);

    // R8: every redirect moves the event count forward by one.
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (clear_count == $past(clear_count) + 1'b1));

    // R8: the count holds when no redirect is issued.
    p_count_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !redir_valid |-> $stable(clear_count));

    // R9: fetch is held in the cycle a redirect appears.
    p_hold_on_redir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> fetch_hold);

    // R9: nothing is acted on while the hold is running.
    p_quiet_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cnt != '0) |=> !redir_valid);

    // R7: squashing only accompanies a redirect.
    p_squash_needs_redir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_mask != '0) |-> redir_valid);

    // R10: predictor updates are only sent alongside a redirect.
    p_update_needs_redir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_op != UPD_NONE) |-> redir_valid);
endmodule

// File: tb/bv_validator_tb.sv
module bv_validator_tb;
    localparam int L    = 2;
    localparam int AW   = 32;
    localparam int LW   = 4;
    localparam int DW   = 16;
    localparam int RD   = 4;
    localparam int HOLD = 8;
    localparam int CW   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [L-1:0]    dv;
    logic [L*3-1:0]  dcls;
    logic [L*AW-1:0] dpc;
    logic [L*LW-1:0] dlen;
    logic [L*DW-1:0] ddisp;
    logic [L-1:0]    phit, ptk;
    logic [L*AW-1:0] ptg;

    logic          redir_valid, upd_always, upd_hint, fetch_hold;
    logic [AW-1:0] redir_pc, upd_pc, upd_target;
    logic [1:0]    upd_op;
    logic [L-1:0]  squash_mask;
    logic [CW-1:0] clear_count;

    bv_validator #(.LANES(L), .ADDR_W(AW), .LEN_W(LW), .DISP_W(DW),
                   .RAS_DEPTH(RD), .HOLD_CYC(HOLD), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dv), .dec_class(dcls),
        .dec_pc(dpc), .dec_len(dlen), .dec_disp(ddisp), .pred_hit(phit),
        .pred_taken(ptk), .pred_target(ptg), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .upd_op(upd_op), .upd_pc(upd_pc),
        .upd_target(upd_target), .upd_always(upd_always), .upd_hint(upd_hint),
        .squash_mask(squash_mask), .fetch_hold(fetch_hold),
        .clear_count(clear_count)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench reference state.
    logic [AW-1:0] mq[$];
    int            mhold = 0;
    logic [CW-1:0] mcnt = '0;

    logic          e_rv, e_alw, e_hint, e_hold;
    logic [AW-1:0] e_rpc, e_upc, e_tgt;
    logic [1:0]    e_op;
    logic [L-1:0]  e_sq;

    function automatic logic [AW-1:0] calc_tgt(input logic [AW-1:0] pc,
        input logic [LW-1:0] len, input logic [DW-1:0] d);
        return pc + AW'(len) + {{(AW-DW){d[DW-1]}}, d};
    endfunction

    task automatic clear_lanes();
        dv = '0; dcls = '0; dpc = '0; dlen = '0; ddisp = '0;
        phit = '0; ptk = '0; ptg = '0;
    endtask

    task automatic set_lane(input int i, input logic [2:0] c, input logic [AW-1:0] pc,
        input logic [LW-1:0] len, input logic [DW-1:0] d, input logic h,
        input logic t, input logic [AW-1:0] g);
        dv[i] = 1'b1; dcls[i*3 +: 3] = c; dpc[i*AW +: AW] = pc;
        dlen[i*LW +: LW] = len; ddisp[i*DW +: DW] = d;
        phit[i] = h; ptk[i] = t; ptg[i*AW +: AW] = g;
    endtask

    // Compute the expected outcome of the driven group, advance the model,
    // clock once and compare at the following falling edge.
    task automatic step(input string tag_in);
        string tag;
        tag = tag_in;
        e_rv = 0; e_rpc = '0; e_op = 0; e_upc = '0; e_tgt = '0;
        e_alw = 0; e_hint = 0; e_sq = '0;
        if (mhold != 0) begin
            mhold--;
            if (tag == "") tag = "R9";
        end else begin
            logic [AW-1:0] q[$];
            bit found;
            q = mq;
            found = 0;
            for (int i = 0; i < L && !found; i++) begin
                logic [AW-1:0] pc, f, t, g;
                logic [2:0] c;
                logic h, tk, mis;
                logic [AW-1:0] npc, ut;
                logic [1:0] op;
                logic al, hi;
                if (!dv[i]) continue;
                c = dcls[i*3 +: 3]; pc = dpc[i*AW +: AW];
                f = pc + AW'(dlen[i*LW +: LW]);
                t = calc_tgt(pc, dlen[i*LW +: LW], ddisp[i*DW +: DW]);
                h = phit[i]; tk = ptk[i]; g = ptg[i*AW +: AW];
                mis = 0; npc = f; op = 0; ut = '0; al = 0; hi = 0;
                case (c)
                    3'd0: begin mis = h; op = 2; end
                    3'd1: begin
                        op = 1; ut = t;
                        if (!h) begin mis = 1; hi = (t < pc); npc = hi ? t : f; end
                        else begin mis = (g != t); hi = tk; npc = tk ? t : f; end
                    end
                    3'd2, 3'd3: begin
                        mis = !h || !tk || (g != t); npc = t; op = 1; ut = t; al = 1; hi = 1;
                        if (c == 3'd3) begin
                            q.push_back(f);
                            if (q.size() > RD) void'(q.pop_front());
                        end
                    end
                    3'd4: begin
                        if (q.size() > 0) begin
                            logic [AW-1:0] top;
                            top = q.pop_back();
                            mis = !h || !tk || (g != top); npc = top; op = 1;
                            ut = top; al = 1; hi = 1;
                        end
                    end
                    default: ;
                endcase
                if (mis) begin
                    found = 1;
                    e_rv = 1; e_rpc = npc; e_op = op; e_upc = pc; e_tgt = ut;
                    e_alw = al; e_hint = hi;
                    for (int j = 0; j < L; j++) e_sq[j] = (j > i);
                    if (tag == "") begin
                        case (c)
                            3'd0: tag = "R1";
                            3'd1: tag = h ? "R3" : "R4";
                            3'd4: tag = "R6";
                            default: tag = "R2";
                        endcase
                    end
                end
            end
            mq = q;
            if (found) begin mhold = HOLD; mcnt = mcnt + 1'b1; end
            if (tag == "") tag = "R10";
        end
        e_hold = (mhold != 0);
        @(posedge clk);
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic check_outputs(input string tag);
        logic [AW*3+CW+L+7-1:0] act, exp;
        act = {redir_valid, redir_pc, upd_op, upd_pc, upd_target, upd_always,
               upd_hint, squash_mask, fetch_hold, clear_count};
        exp = {e_rv, e_rpc, e_op, e_upc, e_tgt, e_alw, e_hint, e_sq, e_hold, mcnt};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drain();
        clear_lanes();
        while (mhold != 0) step("R9");
    endtask

    task automatic rand_group();
        logic [AW-1:0] gq[$];
        gq = mq;
        clear_lanes();
        for (int i = 0; i < L; i++) begin
            logic [2:0] c;
            logic [AW-1:0] pc, t, f;
            logic [LW-1:0] len;
            logic [DW-1:0] d;
            bit good;
            if ($urandom % 8 == 0) continue;
            c = 3'($urandom % 6);
            pc = $urandom; len = LW'(1 + $urandom % 15); d = DW'($urandom);
            f = pc + AW'(len); t = calc_tgt(pc, len, d);
            good = ($urandom % 4 != 0);
            if (!good) begin
                set_lane(i, c, pc, len, d, 1'($urandom), 1'($urandom),
                         ($urandom % 2) ? t : AW'($urandom));
            end else begin
                case (c)
                    3'd0: set_lane(i, c, pc, len, d, 0, 0, '0);
                    3'd1: set_lane(i, c, pc, len, d, 1, 1'($urandom), t);
                    3'd4: set_lane(i, c, pc, len, d, 1, 1, gq.size() > 0 ? gq[$] : '0);
                    default: set_lane(i, c, pc, len, d, 1, 1, t);
                endcase
            end
            if (c == 3'd3) begin gq.push_back(f); if (gq.size() > RD) void'(gq.pop_front()); end
            if (c == 3'd4 && gq.size() > 0) void'(gq.pop_back());
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        clear_lanes();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset values
        e_rv = 0; e_rpc = '0; e_op = 0; e_upc = '0; e_tgt = '0; e_alw = 0;
        e_hint = 0; e_sq = '0; e_hold = 0;
        check_outputs("R11");
        rst_n = 1'b1;

        // R11: empty stack after reset, so a bogus return is not checked
        set_lane(0, 3'd4, 32'h100, 4'd2, '0, 0, 0, 32'h0);
        step("R11");

        // R1: phantom on a non-branch
        clear_lanes(); set_lane(0, 3'd0, 32'h1000, 4'd3, '0, 1, 1, 32'h2000);
        step("R1"); drain();

        // R2: relative jump with no prediction
        clear_lanes(); set_lane(0, 3'd2, 32'h2000, 4'd5, 16'h0040, 0, 0, '0);
        step("R2"); drain();

        // R3: conditional hit, taken, wrong target
        clear_lanes(); set_lane(0, 3'd1, 32'h3000, 4'd2, 16'h0010, 1, 1, 32'h3333);
        step("R3"); drain();
        // R3: conditional hit, right target, not taken -> nothing
        clear_lanes(); set_lane(0, 3'd1, 32'h3000, 4'd2, 16'h0010, 1, 0, 32'h3012);
        step("R3");

        // R4: new backward conditional -> taken; new forward -> not taken
        clear_lanes(); set_lane(0, 3'd1, 32'h4000, 4'd2, 16'hFF00, 0, 0, '0);
        step("R4"); drain();
        clear_lanes(); set_lane(0, 3'd1, 32'h4000, 4'd2, 16'h0100, 0, 0, '0);
        step("R4"); drain();

        // R5: target wraps past the top of the address space
        clear_lanes(); set_lane(0, 3'd2, 32'hFFFF_FFF0, 4'd4, 16'h0010, 1, 1, 32'h0);
        step("R5"); drain();

        // R6: call then a return with the wrong target
        clear_lanes(); set_lane(0, 3'd3, 32'h5000, 4'd5, 16'h0200, 1, 1, 32'h5205);
        step("R6");
        clear_lanes(); set_lane(0, 3'd4, 32'h5205, 4'd1, '0, 1, 1, 32'hDEAD);
        step("R6"); drain();
        // R6: overflow drops the oldest return address
        for (int k = 0; k < RD + 1; k++) begin
            clear_lanes();
            set_lane(0, 3'd3, 32'h6000 + k*32'h100, 4'd4, 16'h0020, 1, 1,
                     calc_tgt(32'h6000 + k*32'h100, 4'd4, 16'h0020));
            step("R6");
        end
        for (int k = RD; k >= 0; k--) begin
            clear_lanes();
            set_lane(0, 3'd4, 32'h7000, 4'd1, '0, 1, 1, 32'h6004 + k*32'h100);
            step("R6");
        end

        // R7: both lanes wrong, lane 0 wins and lane 1 is squashed
        clear_lanes();
        set_lane(0, 3'd0, 32'h8000, 4'd2, '0, 1, 1, 32'h9000);
        set_lane(1, 3'd2, 32'h8002, 4'd2, 16'h0040, 0, 0, '0);
        step("R7"); drain();
        // R7: squashed call must not push; later return is unchecked
        clear_lanes();
        set_lane(0, 3'd0, 32'h8100, 4'd2, '0, 1, 0, 32'h0);
        set_lane(1, 3'd3, 32'h8102, 4'd3, 16'h0010, 1, 1, 32'h8115);
        step("R7"); drain();
        clear_lanes(); set_lane(0, 3'd4, 32'h8200, 4'd1, '0, 0, 0, '0);
        step("R7");
        // R7: lane 1 alone wrong, lane 0 call kept
        clear_lanes();
        set_lane(0, 3'd3, 32'h8300, 4'd2, 16'h0010, 1, 1, 32'h8312);
        set_lane(1, 3'd0, 32'h8312, 4'd2, '0, 1, 1, 32'h1);
        step("R7"); drain();

        // R9: phantom during hold is ignored
        clear_lanes(); set_lane(0, 3'd0, 32'hA000, 4'd2, '0, 1, 1, '0);
        step("R1");
        step("R9"); step("R9");
        drain();

        // R10: indirect with anything, correct jump
        clear_lanes(); set_lane(0, 3'd5, 32'hB000, 4'd2, '0, 0, 0, '0);
        set_lane(1, 3'd2, 32'hB002, 4'd2, 16'h0008, 1, 1, 32'hB00C);
        step("R10");

        // Random traffic (R8 checked through clear_count on every step)
        for (int n = 0; n < 3000; n++) begin
            rand_group();
            step("");
        end
        clear_lanes();
        drain();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule